// File: doc/BRIEF.md
# Six-digit BCD event counter

This block counts pulses from an external event line, which need not be synchronous to the clock, as a six-digit packed BCD value. The raw input passes through a two-flop synchronizer and only its rising edges are counted. Counting runs only while the mode field of the control register selects event mode. Each counted event can also raise an alarm flag when the new count equals a programmed compare value. Each counted event also feeds a decade prescaler, and that prescaler advances a two-digit BCD timer. The timer raises its own flag when it wraps from 99 to 00.

Software programs the block through a single-cycle byte write port. The port decodes a 4-bit register address: 0 is control/flags, 1 to 3 are the count bytes, 7 is the timer, 8 is the alarm control, and 9 to B are the compare bytes. Writes to any other address have no effect. The count, timer and both flags are visible at all times on the output ports.

The sequencing is a three-state machine. ST_OFF is the idle state outside event mode. ST_WAIT means the block is armed and watching for an edge. ST_TALLY is the single cycle in which one event is applied. The transitions are:
- OFF→WAIT when event mode becomes active.
- WAIT→TALLY on a synchronized rising edge.
- TALLY→WAIT after the event has been applied.
- WAIT→OFF or TALLY→OFF whenever event mode is left.

Top module: `evt_bcd_counter`

## Requirements
- R1: After reset the count is 000000, the timer is 00, both flags are 0, the mode field is 00 and the state machine is in ST_OFF.
- R2: An event is counted once per rising edge of the synchronized input, and only while control register (address 0) bits 5:4 equal 2'b10. In any other mode, edges leave the count unchanged. The count changes in the fourth rising clock edge that samples the input high.
- R3: The count increments digit by digit in BCD, with digit 0 in bits 3:0 of address 1 and digit 5 in bits 7:4 of address 3. The count 999999 is followed by 000000.
- R4: When alarm control (address 8) bits 5:4 equal 2'b01 and the incremented count equals the compare bytes at addresses 9, A and B (same digit layout as the count), the alarm flag (control bit 1) is set. Any other code in that field never sets it.
- R5: Alarm control bits 2:0 choose the timer rate: 000 advances the timer on every event, 001 once per 100 events, 010 once per 10 000 events and 011 once per 1 000 000 events. Codes 100 to 111 hold the timer.
- R6: The timer (address 7) counts in BCD from 00 to 99. On the step from 99 it becomes 00 and sets the timer flag (control bit 0).
- R7: A write to any count byte restarts the prescale phase. If that write lands in the tally cycle, the written byte is kept, the other bytes are unchanged, and that event is neither added nor passed to the prescaler or the alarm.
- R8: A flag stays set until a write to address 0 carries 0 in its bit. A flag set in the same cycle as a clearing write stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 1 | Raw external event line, asynchronous |
| wr_en | input | 1 | Register write strobe, one cycle per byte |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 8 | Write data |
| count_o | output | 24 | Packed six-digit BCD count |
| timer_o | output | 8 | Two-digit BCD timer |
| alarm_flag_o | output | 1 | Alarm flag |
| timer_flag_o | output | 1 | Timer overflow flag |

## Verification
Two of this block's functions can fall in the same tally cycle: an alarm match and a timer overflow. A software write that clears the flags can land in that cycle too. To provoke this, the timer is loaded with 99, the compare bytes are set to the value that the next event produces, and a control write with both flag bits 0 is placed in the ST_TALLY cycle. The case is judged correct when both flags read 1 afterwards and the timer reads 00. A second collision places a count-byte write in the tally cycle. It is judged by the written byte standing and by the prescaler needing a full 100 further events before the timer moves.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_TALLY = 2'd2
    } evc_state_e;

    localparam logic [3:0] ADDR_CTRL  = 4'h0;
    localparam logic [3:0] ADDR_CNT0  = 4'h1;
    localparam logic [3:0] ADDR_TIMER = 4'h7;
    localparam logic [3:0] ADDR_ACTL  = 4'h8;
    localparam logic [3:0] ADDR_CMP0  = 4'h9;

    localparam logic [1:0] MODE_EVENT  = 2'b10;
    localparam logic [1:0] AFUNC_EVENT = 2'b01;

    function automatic int unsigned decade_pow(input int unsigned base, input int unsigned e);
        int unsigned r;
        r = 1;
        for (int unsigned k = 0; k < e; k++) r = r * base;
        return r;
    endfunction

endpackage

// File: rtl/evc_sync_edge.sv
module evc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], raw_in};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/evc_bcd_inc.sv
module evc_bcd_inc #(
    parameter int DIGITS = 6
) (
    input  logic [4*DIGITS-1:0] val,
    output logic [4*DIGITS-1:0] nxt,
    output logic                all_nine
);
    logic [DIGITS:0] cy;
    assign cy[0] = 1'b1;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] d;
        assign d            = val[4*i +: 4];
        assign cy[i+1]      = cy[i] & (d == 4'd9);
        assign nxt[4*i +: 4] = !cy[i]      ? d :
                               (d == 4'd9) ? 4'd0 : d + 4'd1;
    end

    assign all_nine = cy[DIGITS];

endmodule

// File: rtl/evc_prescale.sv
module evc_prescale
    import evc_pkg::*;
#(
    parameter int STEP  = 100,
    parameter int CODES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       step,
    input  logic       clear,
    output logic       tick
);
    localparam int SELW   = 3;
    localparam int NSEL   = 2 ** SELW;
    localparam int MAXDIV = int'(decade_pow(STEP, CODES - 1));
    localparam int PW     = (MAXDIV > 1) ? $clog2(MAXDIV) : 1;

    logic [PW-1:0] lim_tab [NSEL];
    logic [PW-1:0] phase_q;
    logic          en;

    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        if (g < CODES) begin : g_used
            assign lim_tab[g] = PW'(decade_pow(STEP, g) - 1);
        end else begin : g_held
            assign lim_tab[g] = '0;
        end
    end

    assign en   = ({1'b0, sel} < (SELW+1)'(CODES));
    assign tick = step & en & (phase_q >= lim_tab[sel]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            phase_q <= '0;
        else if (clear)        phase_q <= '0;
        else if (step && en)   phase_q <= tick ? '0 : phase_q + PW'(1);
    end

    assert_tick_needs_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> step);
    assert_tick_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> phase_q == '0);
    assert_clear_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> phase_q == '0);

endmodule

// File: rtl/evt_bcd_counter.sv
module evt_bcd_counter
    import evc_pkg::*;
#(
    parameter int DIGITS         = 6,
    parameter int TIMER_DIGITS   = 2,
    parameter int SYNC_STAGES    = 2,
    parameter int PRESCALE_STEP  = 100,
    parameter int PRESCALE_CODES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_in,
    input  logic                wr_en,
    input  logic [3:0]          wr_addr,
    input  logic [7:0]          wr_data,
    output logic [4*DIGITS-1:0] count_o,
    output logic [7:0]          timer_o,
    output logic                alarm_flag_o,
    output logic                timer_flag_o
);
    localparam int CW     = 4 * DIGITS;
    localparam int TW     = 4 * TIMER_DIGITS;
    localparam int NBYTES = DIGITS / 2;
    localparam logic [CW-1:0] CNT_ALL9 = {DIGITS{4'h9}};
    localparam logic [TW-1:0] TIM_ALL9 = {TIMER_DIGITS{4'h9}};

    evc_state_e      state_q, state_d;
    logic [1:0]      mode_q, afunc_q;
    logic [2:0]      psel_q;
    logic            aflag_q, tflag_q;
    logic [CW-1:0]   count_q, cmp_q, count_nxt;
    logic [TW-1:0]   timer_q, timer_nxt;
    logic            count_all9, timer_wrap;
    logic            rise, ev_mode, tally, step, tick, aset, tset;
    logic [NBYTES-1:0] cnt_byte_we, cmp_byte_we;
    logic            cnt_wr, ctrl_we, actl_we, timer_we;

    evc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(evt_in), .rise(rise)
    );

    evc_bcd_inc #(.DIGITS(DIGITS)) u_cnt_inc (
        .val(count_q), .nxt(count_nxt), .all_nine(count_all9)
    );

    evc_bcd_inc #(.DIGITS(TIMER_DIGITS)) u_tim_inc (
        .val(timer_q), .nxt(timer_nxt), .all_nine(timer_wrap)
    );

    evc_prescale #(.STEP(PRESCALE_STEP), .CODES(PRESCALE_CODES)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(psel_q), .step(step),
        .clear(cnt_wr), .tick(tick)
    );

    // write decode
    for (genvar b = 0; b < NBYTES; b++) begin : g_wdec
        assign cnt_byte_we[b] = wr_en && (wr_addr == ADDR_CNT0 + 4'(b));
        assign cmp_byte_we[b] = wr_en && (wr_addr == ADDR_CMP0 + 4'(b));
    end
    assign cnt_wr   = |cnt_byte_we;
    assign ctrl_we  = wr_en && (wr_addr == ADDR_CTRL);
    assign actl_we  = wr_en && (wr_addr == ADDR_ACTL);
    assign timer_we = wr_en && (wr_addr == ADDR_TIMER);
    assign ev_mode  = (mode_q == MODE_EVENT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   state_d = ev_mode ? ST_WAIT : ST_OFF;
            ST_WAIT:  state_d = !ev_mode ? ST_OFF : (rise ? ST_TALLY : ST_WAIT);
            ST_TALLY: state_d = ev_mode ? ST_WAIT : ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    // state outputs
    always_comb begin
        tally = (state_q == ST_TALLY);
        step  = tally && !cnt_wr;
        aset  = step && (afunc_q == AFUNC_EVENT) && (count_nxt == cmp_q);
        tset  = tick && timer_wrap && !timer_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            cmp_q   <= '0;
        end else begin
            if (cnt_wr) begin
                for (int b = 0; b < NBYTES; b++)
                    if (cnt_byte_we[b]) count_q[8*b +: 8] <= wr_data;
            end else if (step) begin
                count_q <= count_nxt;
            end
            for (int b = 0; b < NBYTES; b++)
                if (cmp_byte_we[b]) cmp_q[8*b +: 8] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        timer_q <= '0;
        else if (timer_we) timer_q <= wr_data[TW-1:0];
        else if (tick)     timer_q <= timer_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 2'b00;
            afunc_q <= 2'b00;
            psel_q  <= 3'b000;
            aflag_q <= 1'b0;
            tflag_q <= 1'b0;
        end else begin
            if (ctrl_we) mode_q <= wr_data[5:4];
            if (actl_we) begin
                afunc_q <= wr_data[5:4];
                psel_q  <= wr_data[2:0];
            end
            aflag_q <= (ctrl_we ? (aflag_q & wr_data[1]) : aflag_q) | aset;
            tflag_q <= (ctrl_we ? (tflag_q & wr_data[0]) : tflag_q) | tset;
        end
    end

    assign count_o      = count_q;
    assign timer_o      = timer_q;
    assign alarm_flag_o = aflag_q;
    assign timer_flag_o = tflag_q;

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step && count_all9 |=> count_q == '0);
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tally && !cnt_wr |=> $stable(count_q));
    assert_tally_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_TALLY |=> state_q != ST_TALLY);
    assert_timer_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (timer_q == TIM_ALL9) && !timer_we |=> tflag_q && (timer_q == '0));
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        aflag_q && !ctrl_we |=> aflag_q);
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_byte_we[0] |=> count_q[7:0] == $past(wr_data));
    assert_alarm_func_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !aflag_q && (afunc_q != AFUNC_EVENT) && !actl_we |=> !aflag_q);

endmodule

// File: tb/evt_bcd_counter_tb_top.sv
module evt_bcd_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [23:0] count_o;
    logic [7:0]  timer_o;
    logic        alarm_flag_o, timer_flag_o;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_bcd_counter dut_i (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .count_o(count_o),
        .timer_o(timer_o), .alarm_flag_o(alarm_flag_o), .timer_flag_o(timer_flag_o)
    );

    // ---------------- reference model ----------------
    bit [2:0]    m_sh;
    int          m_state;
    logic [23:0] m_cnt, m_cmp;
    logic [7:0]  m_tim;
    bit          m_af, m_tf;
    logic [1:0]  m_mode, m_afunc;
    logic [2:0]  m_psel;
    int          m_phase;

    function automatic int bcd_to_int(input logic [23:0] v);
        int r = 0;
        for (int i = 5; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [23:0] int_to_bcd(input int n);
        logic [23:0] r;
        int x = n;
        for (int i = 0; i < 6; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sh <= '0; m_state <= 0; m_cnt <= '0; m_cmp <= '0; m_tim <= '0;
            m_af <= 0; m_tf <= 0; m_mode <= '0; m_afunc <= '0; m_psel <= '0; m_phase <= 0;
        end else begin
            bit tally, cw, step, en, tick, aset, tset, tw, ev;
            int div;
            logic [23:0] nxt, tnext, ncnt;
            tally = (m_state == 2);
            cw    = wr_en && wr_addr >= 4'h1 && wr_addr <= 4'h3;
            step  = tally && !cw;
            nxt   = int_to_bcd((bcd_to_int(m_cnt) + 1) % 1000000);
            aset  = step && m_afunc == 2'b01 && nxt == m_cmp;
            en    = m_psel <= 3'd3;
            div   = 1;
            for (int k = 0; k < int'(m_psel) && k < 3; k++) div = div * 100;
            tick  = step && en && m_phase >= div - 1;
            tw    = wr_en && wr_addr == 4'h7;
            tset  = tick && !tw && m_tim == 8'h99;
            tnext = int_to_bcd((bcd_to_int({16'h0, m_tim}) + 1) % 100);
            if (cw) m_phase <= 0;
            else if (step && en) m_phase <= tick ? 0 : m_phase + 1;
            if (tw) m_tim <= wr_data;
            else if (tick) m_tim <= tnext[7:0];
            ncnt = m_cnt;
            if (cw) ncnt[8*(int'(wr_addr)-1) +: 8] = wr_data;
            else if (step) ncnt = nxt;
            m_cnt <= ncnt;
            if (wr_en && wr_addr == 4'h9) m_cmp[7:0]   <= wr_data;
            if (wr_en && wr_addr == 4'hA) m_cmp[15:8]  <= wr_data;
            if (wr_en && wr_addr == 4'hB) m_cmp[23:16] <= wr_data;
            if (wr_en && wr_addr == 4'h0) begin
                m_mode <= wr_data[5:4];
                m_af <= (m_af & wr_data[1]) | aset;
                m_tf <= (m_tf & wr_data[0]) | tset;
            end else begin
                m_af <= m_af | aset;
                m_tf <= m_tf | tset;
            end
            if (wr_en && wr_addr == 4'h8) begin
                m_afunc <= wr_data[5:4];
                m_psel  <= wr_data[2:0];
            end
            ev = (m_mode == 2'b10);
            case (m_state)
                0: m_state <= ev ? 1 : 0;
                1: m_state <= !ev ? 0 : ((m_sh[1] && !m_sh[2]) ? 2 : 1);
                default: m_state <= ev ? 1 : 0;
            endcase
            m_sh <= {m_sh[1:0], evt_in};
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(count_o == m_cnt, cur_req, "count", int'(count_o), int'(m_cnt));
            chk(timer_o == m_tim, cur_req, "timer", int'(timer_o), int'(m_tim));
            chk(alarm_flag_o == m_af, cur_req, "alarm flag", int'(alarm_flag_o), int'(m_af));
            chk(timer_flag_o == m_tf, cur_req, "timer flag", int'(timer_flag_o), int'(m_tf));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_LIMIT && !done) begin
            checks++; fails++;
            $display("FAIL watchdog %s: actual %0d cycles expected below %0d", cur_req, cyc, WD_LIMIT);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic events(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); evt_in = 1;
            @(negedge clk);
            @(negedge clk); evt_in = 0;
            @(negedge clk);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one event with a register write placed in its tally cycle
    task automatic event_with_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); evt_in = 1;
        @(negedge clk);
        @(negedge clk); evt_in = 0;
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    initial begin
        settle(3);
        rst_n = 1;
        settle(1);
        // R1: reset state
        chk(count_o == 24'h0 && timer_o == 8'h0, "R1", "reset count/timer", int'(count_o), 0);
        chk(!alarm_flag_o && !timer_flag_o, "R1", "reset flags",
            int'({alarm_flag_o, timer_flag_o}), 0);

        // R2: events ignored outside event mode
        cur_req = "R2";
        events(3); settle(3);
        chk(count_o == 24'h0, "R2", "count outside event mode", int'(count_o), 0);

        wr(4'h0, 8'h20);
        wr(4'h8, 8'h00);
        events(12); settle(3);
        chk(count_o == 24'h000012, "R2", "twelve events", int'(count_o), 24'h12);
        chk(timer_o == 8'h12, "R5", "code 000 every event", int'(timer_o), 8'h12);

        // R3: BCD carry and wrap
        cur_req = "R3";
        wr(4'h1, 8'h95); wr(4'h2, 8'h99); wr(4'h3, 8'h99);
        events(7); settle(3);
        chk(count_o == 24'h000002, "R3", "wrap past 999999", int'(count_o), 24'h2);

        // R4: alarm only with function code 01
        cur_req = "R4";
        wr(4'h9, 8'h05); wr(4'hA, 8'h00); wr(4'hB, 8'h00);
        events(3); settle(3);
        chk(!alarm_flag_o, "R4", "no alarm with code 00", int'(alarm_flag_o), 0);
        wr(4'h8, 8'h10); wr(4'h1, 8'h00);
        events(4); settle(3);
        chk(!alarm_flag_o, "R4", "no alarm before match", int'(alarm_flag_o), 0);
        events(1); settle(3);
        chk(alarm_flag_o, "R4", "alarm on match", int'(alarm_flag_o), 1);

        // R8: flag write semantics
        cur_req = "R8";
        wr(4'h0, 8'h22); settle(1);
        chk(alarm_flag_o, "R8", "writing 1 keeps flag", int'(alarm_flag_o), 1);
        wr(4'h0, 8'h20); settle(1);
        chk(!alarm_flag_o, "R8", "writing 0 clears flag", int'(alarm_flag_o), 0);

        // R6: timer overflow
        cur_req = "R6";
        wr(4'h7, 8'h97);
        events(3); settle(3);
        chk(timer_o == 8'h00 && timer_flag_o, "R6", "timer 99 to 00 with flag",
            int'({timer_flag_o, timer_o}), 9'h100);
        wr(4'h0, 8'h20);

        // R5: prescale codes
        cur_req = "R5";
        wr(4'h8, 8'h01); wr(4'h1, 8'h00); wr(4'h7, 8'h00);
        events(99); settle(3);
        chk(timer_o == 8'h00, "R5", "code 001 after 99", int'(timer_o), 0);
        events(1); settle(3);
        chk(timer_o == 8'h01, "R5", "code 001 after 100", int'(timer_o), 1);
        events(150); settle(3);
        chk(timer_o == 8'h02, "R5", "code 001 after 250", int'(timer_o), 2);
        wr(4'h8, 8'h02); wr(4'h1, 8'h00); wr(4'h7, 8'h00);
        events(9999); settle(3);
        chk(timer_o == 8'h00, "R5", "code 010 after 9999", int'(timer_o), 0);
        events(1); settle(3);
        chk(timer_o == 8'h01, "R5", "code 010 after 10000", int'(timer_o), 1);
        wr(4'h8, 8'h03); wr(4'h1, 8'h00); wr(4'h7, 8'h00);
        events(200); settle(3);
        chk(timer_o == 8'h00, "R5", "code 011 holds over 200", int'(timer_o), 0);
        wr(4'h8, 8'h04);
        events(5); settle(3);
        chk(timer_o == 8'h00, "R5", "code 100 holds timer", int'(timer_o), 0);

        // R7: count write in the tally cycle, prescale restart
        cur_req = "R7";
        wr(4'h8, 8'h01); wr(4'h1, 8'h00); wr(4'h2, 8'h00); wr(4'h3, 8'h00); wr(4'h7, 8'h00);
        events(60);
        event_with_write(4'h1, 8'h40); settle(3);
        chk(count_o == 24'h000040, "R7", "write wins over tally", int'(count_o), 24'h40);
        events(99); settle(3);
        chk(timer_o == 8'h00, "R7", "phase restarted by write", int'(timer_o), 0);
        events(1); settle(3);
        chk(timer_o == 8'h01 && count_o == 24'h000140, "R7", "tick after 100 more",
            int'(timer_o), 1);

        // R8 with R4/R6: alarm and overflow together against a clearing write
        cur_req = "R8";
        wr(4'h8, 8'h10); wr(4'h7, 8'h99);
        wr(4'h9, 8'h41); wr(4'hA, 8'h01); wr(4'hB, 8'h00);
        event_with_write(4'h0, 8'h20); settle(3);
        chk(alarm_flag_o && timer_flag_o, "R8", "set wins over clear",
            int'({alarm_flag_o, timer_flag_o}), 3);
        chk(timer_o == 8'h00 && count_o == 24'h000141, "R6", "overflow with match",
            int'(timer_o), 0);
        events(2); settle(3);
        chk(alarm_flag_o && timer_flag_o, "R8", "flags sticky",
            int'({alarm_flag_o, timer_flag_o}), 3);

        // R2: leaving event mode stops counting
        cur_req = "R2";
        wr(4'h0, 8'h00);
        events(4); settle(3);
        chk(count_o == 24'h000143, "R2", "mode 00 freezes count", int'(count_o), 24'h143);

        finish_run();
    end

endmodule